// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire PHY management bus. It carries out Clause 22 read and write transactions. Software sees two 32-bit registers on a simple write/read port: a command register and a data register. One write to the command register with its go bit set starts a transaction. From that one write the block takes the operation, the PHY address, the PHY register address and the management clock divider.

The block derives MDC from the system clock and shifts a 64-bit frame out on MDIO. The pin is driven through separate output, output-enable and input signals. On a read it releases the line for the turnaround and the data field. It samples the PHY's answer on the rising edges of MDC and places the 16-bit result in the data register as the busy flag clears. Software polls the busy flag to know when a result is ready or when the next command may be issued.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc and mdioOe are 0 and both registers read as 0.
- R2: Command register layout (regSel=0): bit 0 go/busy, bit 1 write (1) or read (0), bits 8:4 register address, bits 16:12 PHY address, bits 21:20 divider select; all other bits read 0. A command written with bit 0 clear stores its fields, reads them back, and starts no transaction (mdc stays low).
- R3: Divider select 0, 1, 2 and 3 gives an MDC period of 16, 32, 64 and 128 system clocks; MDC is low whenever no transaction is in progress.
- R4: A write frame is 64 MDC bits, in this order: 32 ones, start 01, opcode 01, PHY address MSB first, register address MSB first, turnaround 10, then the 16 bits of the data register (regSel=1, bits 15:0) MSB first. mdioOe is 1 for all 64 bits.
- R5: A read frame carries opcode 10, drives the first 46 bits in the same order as R4, and holds mdioOe at 0 for both turnaround bits and all 16 data bits.
- R6: On a read, mdioIn is sampled on the 16 MDC rising edges of the data field, MSB first, and the data register reads the result once busy has cleared.
- R7: Busy (command bit 0) reads 1 right after a starting command write and clears at the MDC falling edge that ends bit 64. Afterwards mdc and mdioOe are 0, and the command fields still read back.
- R8: Command-register and data-register writes made while busy is 1 are ignored. The frame in progress, the stored fields and the read result are unaffected, and no second transaction follows.
- R9: While a transaction runs, mdioOut and the bit position change only at an MDC falling edge, and the frame begins with a preamble one as busy rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe, one cycle per write |
| regSel | input | 1 | Register select: 0 command, 1 data |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Management data driven by the master |
| mdioOe | output | 1 | Output enable for mdioOut; 0 releases the line |
| mdioIn | input | 1 | Management data seen on the line |

## Verification
The assertions assume that regWe is a single-cycle strobe and that software does not change the data register between a read's completion and its readback. They also assume the PHY changes mdioIn only away from the system clock edge at which MDC rises. The bench writes registers at the falling edge of clk. Its PHY model updates mdioIn at the falling edge of MDC, half an MDC period before the master samples. The model keeps the line pulled high outside the data field. Commands issued during a busy transaction come well inside the frame, so they never coincide with the completing edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int BUS_W  = 32;
  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 2;

  // Decoded command fields as written by software
  typedef struct packed {
    logic              go;
    logic              isWrite;
    logic [PHY_AW-1:0] phyAddr;
    logic [REG_AW-1:0] regAddr;
    logic [DIV_W-1:0]  divSel;
  } cmd_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic              isWrite;
    logic [PHY_AW-1:0] phyAddr;
    logic [REG_AW-1:0] regAddr;
    logic              shift;
    logic              sample;
    logic              commit;
  } strobe_t;

  function automatic cmd_t wordToCmd(input logic [BUS_W-1:0] w);
    cmd_t c;
    c.go      = w[0];
    c.isWrite = w[1];
    c.regAddr = w[8:4];
    c.phyAddr = w[16:12];
    c.divSel  = w[21:20];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] cmdToWord(input logic busy, input cmd_t c);
    logic [BUS_W-1:0] w;
    w        = '0;
    w[0]     = busy;
    w[1]     = c.isWrite;
    w[8:4]   = c.regAddr;
    w[16:12] = c.phyAddr;
    w[21:20] = c.divSel;
    return w;
  endfunction

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_LEN   = 32,
  parameter int BASE_HALF = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWe,
  input  cmd_t             cmdIn,
  output logic             busy,
  output logic [BUS_W-1:0] cmdWord,
  output logic             mdc,
  output logic             driveEn,
  output strobe_t          st
);

  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int CNT_W     = $clog2(BASE_HALF * 8 + 1);
  localparam int TA_IDX    = PRE_LEN + 14;
  localparam int DATA_IDX  = PRE_LEN + 16;

  logic             busyQ;
  cmd_t             cmdQ;
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] halfLen;
  logic [IDX_W-1:0] bitIdx;
  logic             mdcQ;
  logic             tick;
  logic             riseEv;
  logic             fallEv;
  logic             lastBit;
  logic             startReq;

  assign halfLen  = CNT_W'(BASE_HALF) << cmdQ.divSel;
  assign tick     = busyQ && (divCnt == halfLen - CNT_W'(1));
  assign riseEv   = tick && !mdcQ;
  assign fallEv   = tick && mdcQ;
  assign lastBit  = (bitIdx == IDX_W'(FRAME_LEN - 1));
  assign startReq = cmdWe && !busyQ && cmdIn.go;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      cmdQ   <= '0;
      divCnt <= '0;
      bitIdx <= '0;
      mdcQ   <= 1'b0;
    end else if (cmdWe && !busyQ) begin
      cmdQ   <= cmdIn;
      cmdQ.go <= 1'b0;
      busyQ  <= cmdIn.go;
      divCnt <= '0;
      bitIdx <= '0;
      mdcQ   <= 1'b0;
    end else if (busyQ) begin
      if (tick) begin
        divCnt <= '0;
        mdcQ   <= !mdcQ;
      end else begin
        divCnt <= divCnt + CNT_W'(1);
      end
      if (fallEv) begin
        if (lastBit) busyQ  <= 1'b0;
        else         bitIdx <= bitIdx + IDX_W'(1);
      end
    end
  end

  always_comb begin
    st         = '0;
    st.load    = startReq;
    st.isWrite = cmdIn.isWrite;
    st.phyAddr = cmdIn.phyAddr;
    st.regAddr = cmdIn.regAddr;
    st.shift   = fallEv && !lastBit;
    st.sample  = riseEv && !cmdQ.isWrite && (bitIdx >= IDX_W'(DATA_IDX));
    st.commit  = fallEv && lastBit && !cmdQ.isWrite;
  end

  assign busy    = busyQ;
  assign mdc     = mdcQ;
  assign driveEn = busyQ && (cmdQ.isWrite || (bitIdx < IDX_W'(TA_IDX)));
  assign cmdWord = cmdToWord(busyQ, cmdQ);

  // R3: no MDC activity outside a transaction
  a_r3_mdc_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !mdcQ);

  // R9: the frame position advances only on a falling MDC edge
  a_r9_step_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ) && $changed(bitIdx)) |-> $fell(mdcQ));

  // R7: busy ends together with a falling MDC edge
  a_r7_busy_ends_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> $fell(mdcQ));

  // R8: command fields are locked while busy
  a_r8_cmd_locked: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cmdWe) |=> ($stable(cmdQ) && busyQ == $past(busyQ && !(fallEv && lastBit))));

endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  strobe_t           st,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataWdata,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic [DATA_W-1:0] dataWord
);

  localparam int FRAME_LEN = PRE_LEN + 32;

  logic [FRAME_LEN-1:0] frameQ;
  logic [DATA_W-1:0]    dataQ;
  logic [DATA_W-1:0]    captQ;
  logic [FRAME_LEN-1:0] frameNew;

  always_comb begin
    frameNew = {{PRE_LEN{1'b1}}, 2'b01,
                (st.isWrite ? 2'b01 : 2'b10),
                st.phyAddr, st.regAddr,
                (st.isWrite ? 2'b10 : 2'b11),
                (st.isWrite ? dataQ : {DATA_W{1'b1}})};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ <= '1;
      dataQ  <= '0;
      captQ  <= '0;
    end else begin
      if (st.load)
        frameQ <= frameNew;
      else if (st.shift)
        frameQ <= {frameQ[FRAME_LEN-2:0], 1'b1};
      if (st.sample)
        captQ <= {captQ[DATA_W-2:0], mdioIn};
      if (st.commit)
        dataQ <= captQ;
      else if (dataWe && !busy)
        dataQ <= dataWdata;
    end
  end

  assign mdioOut  = frameQ[FRAME_LEN-1];
  assign dataWord = dataQ;

  // R9: each frame opens with a preamble one
  a_r9_start_preamble: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> mdioOut);

  // R6: data is only sampled inside a transaction
  a_r6_sample_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    (st.sample || st.shift || st.commit) |-> busy);

  // R8: software cannot disturb the data register mid-transaction
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dataWe && !st.commit) |=> $stable(dataQ));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PRE_LEN   = 32,
  parameter int BASE_HALF = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regSel,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  logic              busy;
  logic [BUS_W-1:0]  cmdWord;
  logic [DATA_W-1:0] dataWord;
  logic              driveEn;
  strobe_t           st;
  cmd_t              cmdIn;
  wire               unusedWbits = ^{regWdata[31:22], regWdata[19:17],
                                     regWdata[11:9], regWdata[3:2]};

  assign cmdIn = wordToCmd(regWdata);

  mdio_ctrl #(.PRE_LEN(PRE_LEN), .BASE_HALF(BASE_HALF)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdWe   (regWe && !regSel),
    .cmdIn   (cmdIn),
    .busy    (busy),
    .cmdWord (cmdWord),
    .mdc     (mdc),
    .driveEn (driveEn),
    .st      (st)
  );

  mdio_datapath #(.PRE_LEN(PRE_LEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .busy      (busy),
    .st        (st),
    .dataWe    (regWe && regSel),
    .dataWdata (regWdata[DATA_W-1:0]),
    .mdioIn    (mdioIn),
    .mdioOut   (mdioOut),
    .dataWord  (dataWord)
  );

  assign mdioOe   = driveEn;
  assign regRdata = regSel ? {{(BUS_W-DATA_W){1'b0}}, dataWord} : cmdWord;

  // R5: the line is never driven outside a transaction
  a_r5_release_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_master u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY model: records each bit on MDC rise, answers reads after MDC fall
  logic [63:0] captBits, captOe;
  logic [15:0] phyData = 16'h0;
  int          riseCnt = 0;
  longint      lastRise = 0;
  longint      minPer = 0, maxPer = 0;

  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      captBits[63-riseCnt] = mdioOut;
      captOe[63-riseCnt]   = mdioOe;
    end
    if (riseCnt > 0) begin
      if (cyc - lastRise < minPer) minPer = cyc - lastRise;
      if (cyc - lastRise > maxPer) maxPer = cyc - lastRise;
    end
    lastRise = cyc;
    riseCnt++;
  end

  always @(negedge mdc) begin
    if (riseCnt >= 48 && riseCnt <= 63) mdioIn <= phyData[63-riseCnt];
    else                                 mdioIn <= 1'b1;
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clearCapture();
    riseCnt  = 0;
    captBits = '0;
    captOe   = '0;
    minPer   = 64'd1000000;
    maxPer   = 0;
  endtask

  task automatic busWrite(input logic sel, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic busRead(input logic sel, output logic [31:0] d);
    @(negedge clk);
    regSel = sel;
    #1 d = regRdata;
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] v;
    int n;
    n = 0;
    busRead(1'b0, v);
    while (v[0] && n < 20000) begin
      busRead(1'b0, v);
      n++;
    end
    check(!v[0], tag, 64'(v[0]), 64'd0);
  endtask

  function automatic logic [31:0] mkCmd(input logic go, input logic wr, input logic [4:0] phy,
                                        input logic [4:0] rg, input logic [1:0] dv);
    logic [31:0] w;
    w = '0;
    w[0] = go; w[1] = wr; w[8:4] = rg; w[16:12] = phy; w[21:20] = dv;
    return w;
  endfunction

  task automatic testReset();
    logic [31:0] v;
    @(negedge clk);
    check(mdc == 1'b0, "R1 mdc after reset", 64'(mdc), 64'd0);
    check(mdioOe == 1'b0, "R1 mdioOe after reset", 64'(mdioOe), 64'd0);
    busRead(1'b0, v);
    check(v == 32'h0, "R1 command register after reset", 64'(v), 64'd0);
    busRead(1'b1, v);
    check(v == 32'h0, "R1 data register after reset", 64'(v), 64'd0);
  endtask

  task automatic testWrite(input logic [4:0] phy, input logic [4:0] rg, input logic [1:0] dv, input logic [15:0] d);
    logic [31:0] v;
    logic [63:0] expFrame;
    longint expPer;
    expFrame = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d};
    expPer   = 64'd16 << dv;
    busWrite(1'b1, {16'h0, d});
    clearCapture();
    busWrite(1'b0, mkCmd(1'b1, 1'b1, phy, rg, dv));
    busRead(1'b0, v);
    check(v[0] == 1'b1, "R7 busy set after start", 64'(v[0]), 64'd1);
    waitIdle("R7 busy clears after write");
    check(riseCnt == 64, "R4 MDC rising edges per frame", 64'(riseCnt), 64'd64);
    check(captBits == expFrame, "R4 R9 write frame bits", captBits, expFrame);
    check(captOe == '1, "R4 output enable during write", captOe, '1);
    check(minPer == expPer && maxPer == expPer, "R3 MDC period", 64'(maxPer), 64'(expPer));
    check(mdc == 1'b0 && mdioOe == 1'b0, "R7 R3 idle after write", {62'h0, mdc, mdioOe}, 64'd0);
    busRead(1'b0, v);
    check(v == mkCmd(1'b0, 1'b1, phy, rg, dv), "R2 R7 command fields retained", 64'(v), 64'(mkCmd(1'b0, 1'b1, phy, rg, dv)));
    busRead(1'b1, v);
    check(v == {16'h0, d}, "R4 data register keeps write value", 64'(v), 64'(d));
  endtask

  task automatic testRead(input logic [4:0] phy, input logic [4:0] rg, input logic [1:0] dv, input logic [15:0] d);
    logic [31:0] v;
    logic [45:0] expHead;
    longint expPer;
    expHead = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg};
    expPer  = 64'd16 << dv;
    phyData = d;
    clearCapture();
    busWrite(1'b0, mkCmd(1'b1, 1'b0, phy, rg, dv));
    waitIdle("R7 busy clears after read");
    check(riseCnt == 64, "R5 MDC rising edges per read frame", 64'(riseCnt), 64'd64);
    check(captBits[63:18] == expHead, "R5 read frame header", 64'(captBits[63:18]), 64'(expHead));
    check(captOe[63:18] == '1 && captOe[17:0] == '0, "R5 output enable during read", captOe, {46'h3FFF_FFFF_FFFF, 18'h0});
    check(minPer == expPer && maxPer == expPer, "R3 MDC period on read", 64'(maxPer), 64'(expPer));
    busRead(1'b1, v);
    check(v == {16'h0, d}, "R6 read result in data register", 64'(v), 64'(d));
  endtask

  task automatic testBusyIgnored();
    logic [31:0] v;
    phyData = 16'h6E17;
    clearCapture();
    busWrite(1'b0, mkCmd(1'b1, 1'b0, 5'd3, 5'd7, 2'd0));
    repeat (100) @(negedge clk);
    busWrite(1'b0, mkCmd(1'b1, 1'b1, 5'd9, 5'd2, 2'd1));
    busWrite(1'b1, 32'h0000_1111);
    waitIdle("R8 busy clears");
    check(captBits[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd3, 5'd7}, "R8 frame unaffected by write while busy",
          64'(captBits[63:18]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, 5'd3, 5'd7}));
    busRead(1'b0, v);
    check(v == mkCmd(1'b0, 1'b0, 5'd3, 5'd7, 2'd0), "R8 command fields unchanged", 64'(v),
          64'(mkCmd(1'b0, 1'b0, 5'd3, 5'd7, 2'd0)));
    busRead(1'b1, v);
    check(v == 32'h0000_6E17, "R8 read result not overwritten", 64'(v), 64'h6E17);
    repeat (300) @(negedge clk);
    check(riseCnt == 64 && mdc == 1'b0, "R8 no second transaction", 64'(riseCnt), 64'd64);
  endtask

  task automatic testNoGo();
    logic [31:0] v;
    clearCapture();
    busWrite(1'b0, mkCmd(1'b0, 1'b1, 5'h0A, 5'h15, 2'd2));
    repeat (300) @(negedge clk);
    check(riseCnt == 0 && mdc == 1'b0, "R2 no transaction without go", 64'(riseCnt), 64'd0);
    busRead(1'b0, v);
    check(v == mkCmd(1'b0, 1'b1, 5'h0A, 5'h15, 2'd2), "R2 command field layout", 64'(v),
          64'(mkCmd(1'b0, 1'b1, 5'h0A, 5'h15, 2'd2)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWrite(5'd5, 5'h11, 2'd0, 16'hA5C3);
    testRead(5'h1F, 5'h00, 2'd1, 16'h3C5A);
    testRead(5'h00, 5'h1F, 2'd3, 16'h8001);
    testWrite(5'h10, 5'h01, 2'd2, 16'h0000);
    testBusyIgnored();
    testNoGo();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule